// File: doc/BRIEF.md
# Parallel-port pixel peripheral with prefetch

This block sits on the device side of an Enhanced Parallel Port link. A host uses the link to pull image bytes out of a frame buffer and to exchange one control byte and one status byte. The host signals each transfer with an active-low data strobe or an active-low address strobe, together with a write line. The block answers on a wait line and drives the 8-bit bus only while the host is reading. The strobes and the write line are asynchronous. They are synchronized and edge-detected in the system clock domain.

Image bytes go to the host through a one-byte prefetch register. That register is filled from the frame buffer's read port. A fetch is allowed only after a new frame has begun to be stored and enough bytes of that frame have been written. A byte the host has not yet collected is never overwritten. Address write cycles carry control bits out to camera and memory logic. Address read cycles return error, ready and bus-line status.

Top module: `epp_pixel_port`

## Requirements
- R1: When reset is low, waitAck is low, busOe is low, ctrlOut is zero, the prefetch register is empty and frame tracking is disarmed. No fetch takes place after reset until newFrame has been seen again.
- R2: A data read is the data strobe low while the write line is high. The block answers it by raising waitAck with the prefetched byte on busOut.
- R3: Once the host returns the strobe high, the block drops waitAck and busOe together, and the next cycle can then begin.
- R4: If a data read starts while the prefetch register is empty, waitAck stays low until a fetched byte has arrived. The cycle is then acknowledged with that byte.
- R5: An address write is the address strobe low while the write line is low. It loads the 8-bit busIn value into ctrlOut. The bits are: [0] SCL drive, [1] SDA drive, [2] frame memory reset request, [3] camera reset request, [4] camera select, [7:5] stored but unused.
- R6: An address read is the address strobe low while the write line is high. It returns the status byte {3'b000, sdaIn, sclIn, memReady, errFlags[1:0]}.
- R7: A data write is acknowledged on waitAck. The written byte is discarded: ctrlOut, the held pixel and the fetch count all stay unchanged.
- R8: memRdEn is asserted only after newFrame has been seen and at least FETCH_THRESHOLD memWrite pulses (600 by default) have followed the latest newFrame. A newFrame pulse restarts that count.
- R9: No fetch is issued while a prefetched byte is still unread, and a held byte keeps its value until a data read takes it.
- R10: memRdData is captured on the cycle after memRdEn. Bytes reach the host in the order they were fetched.
- R11: busOe is high only during an acknowledged read cycle (data or address). At every other time the bus is released.
- R12: ctrlOut changes only on an address write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low reset line |
| dataStrobeN | input | 1 | Host data strobe, active low, asynchronous |
| addrStrobeN | input | 1 | Host address strobe, active low, asynchronous |
| writeN | input | 1 | Host write line: low means write, high means read |
| busIn | input | 8 | Value the host places on the bus |
| busOut | output | 8 | Value driven onto the bus during reads |
| busOe | output | 1 | Bus output enable; low means high-impedance |
| waitAck | output | 1 | Wait/acknowledge handshake to the host |
| newFrame | input | 1 | Pulse: the frame buffer started storing a new frame |
| memWrite | input | 1 | Pulse: one byte written into the frame buffer |
| memRdEn | output | 1 | Read request to the frame buffer |
| memRdData | input | 8 | Frame buffer read data, valid the cycle after memRdEn |
| errFlags | input | 2 | Two error flags reported in status |
| memReady | input | 1 | Frame memory ready flag reported in status |
| sclIn | input | 1 | Sampled camera SCL line, asynchronous |
| sdaIn | input | 1 | Sampled camera SDA line, asynchronous |
| ctrlOut | output | 8 | Control register contents |

## Verification
The hardest case to reach from the ports is a data read that finds the prefetch register empty. In normal operation the fetch count stays saturated and a new byte is fetched within a few cycles of each read. To reach the empty case, the stimulus pulses newFrame while a byte is held and drains that byte. It then opens a read and holds the strobe low for many cycles. During that time it feeds 599 frame-buffer writes, confirms the wait line is still low, and then supplies the one write that finally releases the acknowledge. The same sequence checks the fetch threshold one byte below and exactly at its limit.

// File: rtl/epp_pkg.sv
package epp_pkg;
  parameter int EPP_BUS_W = 8;

  typedef enum logic [1:0] {
    CYC_DATA_RD,
    CYC_DATA_WR,
    CYC_ADDR_RD,
    CYC_ADDR_WR
  } cycKindT;

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } hostStateT;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic loadCtrl;
    logic takeByte;
    logic driveData;
    logic driveStatus;
  } dpStrobesT;
endpackage

// File: rtl/epp_sync.sv
module epp_sync #(
  parameter int WIDTH = 1,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) stage[s] <= INIT;
        else if (s == 0) stage[s] <= asyncIn;
        else stage[s] <= stage[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign syncOut = stage[STAGES-1];
endmodule

// File: rtl/epp_ctrl.sv
module epp_ctrl
  import epp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      dsN,
  input  logic      asN,
  input  logic      wrN,
  input  logic      pfValid,
  output logic      waitAck,
  output dpStrobesT strobes
);
  hostStateT state;
  cycKindT   kind;
  logic      dsPrev, asPrev, acked;
  logic      dsFall, asFall, strobeHigh, kindReady, ackNow;

  assign dsFall = dsPrev & ~dsN;
  assign asFall = asPrev & ~asN;

  always_comb begin
    strobeHigh = (kind == CYC_DATA_RD || kind == CYC_DATA_WR) ? dsN : asN;
    kindReady  = (kind != CYC_DATA_RD) || pfValid;
    ackNow     = (state == ST_BUSY) && !acked && kindReady && !strobeHigh;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dsPrev <= 1'b1;
      asPrev <= 1'b1;
      state  <= ST_IDLE;
      kind   <= CYC_DATA_RD;
      acked  <= 1'b0;
    end else begin
      dsPrev <= dsN;
      asPrev <= asN;
      case (state)
        ST_IDLE: begin
          if (dsFall) begin
            kind  <= wrN ? CYC_DATA_RD : CYC_DATA_WR;
            state <= ST_BUSY;
          end else if (asFall) begin
            kind  <= wrN ? CYC_ADDR_RD : CYC_ADDR_WR;
            state <= ST_BUSY;
          end
        end
        ST_BUSY: begin
          if (strobeHigh) begin
            state <= ST_IDLE;
            acked <= 1'b0;
          end else if (ackNow) begin
            acked <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.loadCtrl    = ackNow && (kind == CYC_ADDR_WR);
    strobes.takeByte    = (state == ST_BUSY) && acked && strobeHigh && (kind == CYC_DATA_RD);
    strobes.driveData   = (state == ST_BUSY) && acked && (kind == CYC_DATA_RD);
    strobes.driveStatus = (state == ST_BUSY) && acked && (kind == CYC_ADDR_RD);
  end

  assign waitAck = acked;
endmodule

// File: rtl/epp_datapath.sv
module epp_datapath
  import epp_pkg::*;
#(
  parameter int FETCH_THRESHOLD = 600
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  dpStrobesT            strobes,
  input  logic [EPP_BUS_W-1:0] busIn,
  input  logic                 newFrame,
  input  logic                 memWrite,
  input  logic [EPP_BUS_W-1:0] memRdData,
  input  logic [1:0]           errFlags,
  input  logic                 memReady,
  input  logic                 sclS,
  input  logic                 sdaS,
  output logic [EPP_BUS_W-1:0] busOut,
  output logic                 busOe,
  output logic                 memRdEn,
  output logic [EPP_BUS_W-1:0] ctrlReg,
  output logic [EPP_BUS_W-1:0] pfData,
  output logic                 pfValid,
  output logic                 fetchPending
);
  localparam int CNT_W = $clog2(FETCH_THRESHOLD + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(FETCH_THRESHOLD);
  localparam int PAD_W = EPP_BUS_W - 6;

  logic             frameArmed, thresholdMet;
  logic [CNT_W-1:0] wrCount;
  logic [EPP_BUS_W-1:0] statusByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameArmed <= 1'b0;
      wrCount    <= '0;
    end else if (newFrame) begin
      frameArmed <= 1'b1;
      wrCount    <= '0;
    end else if (frameArmed && memWrite && wrCount != CNT_LIMIT) begin
      wrCount <= wrCount + 1'b1;
    end
  end

  assign thresholdMet = frameArmed && (wrCount == CNT_LIMIT);
  assign memRdEn      = thresholdMet && !pfValid && !fetchPending;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      fetchPending <= 1'b0;
      pfValid      <= 1'b0;
      pfData       <= '0;
    end else begin
      fetchPending <= memRdEn;
      if (fetchPending) begin
        pfData  <= memRdData;
        pfValid <= 1'b1;
      end else if (strobes.takeByte) begin
        pfValid <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) ctrlReg <= '0;
    else if (strobes.loadCtrl) ctrlReg <= busIn;
  end

  assign statusByte = {{PAD_W{1'b0}}, sdaS, sclS, memReady, errFlags};
  assign busOut     = strobes.driveData ? pfData : statusByte;
  assign busOe      = strobes.driveData | strobes.driveStatus;
endmodule

// File: rtl/epp_pixel_port.sv
module epp_pixel_port
  import epp_pkg::*;
#(
  parameter int FETCH_THRESHOLD = 600
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataStrobeN,
  input  logic       addrStrobeN,
  input  logic       writeN,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busOe,
  output logic       waitAck,
  input  logic       newFrame,
  input  logic       memWrite,
  output logic       memRdEn,
  input  logic [7:0] memRdData,
  input  logic [1:0] errFlags,
  input  logic       memReady,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic [7:0] ctrlOut
);
  logic [2:0] hostS;
  logic [1:0] lineS;
  logic       dsNS, asNS, wrNS;
  logic       pfValid, fetchPending;
  logic [7:0] pfData;
  dpStrobesT  strobes;

  epp_sync #(.WIDTH(3), .STAGES(2), .INIT(3'b111)) uHostSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({dataStrobeN, addrStrobeN, writeN}),
    .syncOut(hostS)
  );

  epp_sync #(.WIDTH(2), .STAGES(2), .INIT(2'b11)) uLineSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({sclIn, sdaIn}),
    .syncOut(lineS)
  );

  assign dsNS = hostS[2];
  assign asNS = hostS[1];
  assign wrNS = hostS[0];

  epp_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .dsN(dsNS), .asN(asNS), .wrN(wrNS),
    .pfValid(pfValid),
    .waitAck(waitAck),
    .strobes(strobes)
  );

  epp_datapath #(.FETCH_THRESHOLD(FETCH_THRESHOLD)) uData (
    .clk(clk), .rstN(rstN),
    .strobes(strobes),
    .busIn(busIn),
    .newFrame(newFrame), .memWrite(memWrite), .memRdData(memRdData),
    .errFlags(errFlags), .memReady(memReady),
    .sclS(lineS[1]), .sdaS(lineS[0]),
    .busOut(busOut), .busOe(busOe), .memRdEn(memRdEn),
    .ctrlReg(ctrlOut),
    .pfData(pfData), .pfValid(pfValid), .fetchPending(fetchPending)
  );
endmodule

// File: rtl/epp_pixel_port_chk.sv
module epp_pixel_port_chk #(
  parameter int FETCH_THRESHOLD = 600
) (
  input logic       clk,
  input logic       rstN,
  input logic       memRdEn,
  input logic       newFrame,
  input logic       memWrite,
  input logic       pfValid,
  input logic [7:0] pfData,
  input logic       fetchPending,
  input logic       takeByte,
  input logic       loadCtrl,
  input logic [7:0] ctrlOut,
  input logic       busOe,
  input logic       waitAck,
  input logic       wrNS
);
  int   seenWrites;
  logic seenFrame;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenFrame  <= 1'b0;
      seenWrites <= 0;
    end else if (newFrame) begin
      seenFrame  <= 1'b1;
      seenWrites <= 0;
    end else if (seenFrame && memWrite && seenWrites < FETCH_THRESHOLD) begin
      seenWrites <= seenWrites + 1;
    end
  end

  // R8: fetch only after a frame start and enough written bytes
  assert_fetch_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |-> (seenFrame && seenWrites >= FETCH_THRESHOLD));

  // R9: an unread byte is held unchanged
  assert_no_overwrite_R9: assert property (@(posedge clk) disable iff (!rstN)
    (pfValid && !takeByte) |=> (pfValid && $stable(pfData)));

  // R10: capture follows the request by one cycle
  assert_capture_timing_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfValid) |-> $past(fetchPending));

  // R4: a byte is consumed only when one is held
  assert_take_valid_R4: assert property (@(posedge clk) disable iff (!rstN)
    takeByte |-> pfValid);

  // R11: bus driven only with acknowledge during a read
  assert_bus_read_only_R11: assert property (@(posedge clk) disable iff (!rstN)
    busOe |-> (waitAck && wrNS));

  // R3: release of the handshake also releases the bus
  assert_release_together_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(waitAck) |-> !busOe);

  // R12: control register moves only on address writes
  assert_ctrl_stable_R12: assert property (@(posedge clk) disable iff (!rstN)
    !loadCtrl |=> $stable(ctrlOut));
endmodule

bind epp_pixel_port epp_pixel_port_chk #(.FETCH_THRESHOLD(FETCH_THRESHOLD)) uChk (
  .clk(clk), .rstN(rstN),
  .memRdEn(memRdEn), .newFrame(newFrame), .memWrite(memWrite),
  .pfValid(pfValid), .pfData(pfData), .fetchPending(fetchPending),
  .takeByte(strobes.takeByte), .loadCtrl(strobes.loadCtrl),
  .ctrlOut(ctrlOut), .busOe(busOe), .waitAck(waitAck), .wrNS(wrNS)
);

// File: tb/epp_pixel_port_test.sv
module epp_pixel_port_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       dsN = 1'b1, asN = 1'b1, wrN = 1'b1;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic       busOe, waitAck, memRdEn;
  logic       newFrame = 1'b0, memWrite = 1'b0;
  logic [7:0] memRdData = '0;
  logic [1:0] errFlags = '0;
  logic       memReady = 1'b0, sclIn = 1'b1, sdaIn = 1'b1;
  logic [7:0] ctrlOut;

  int nChk = 0, nFail = 0, fetches = 0, readIdx = 0;

  always #2ns clk = ~clk;

  epp_pixel_port uut (
    .clk(clk), .rstN(rstN),
    .dataStrobeN(dsN), .addrStrobeN(asN), .writeN(wrN),
    .busIn(busIn), .busOut(busOut), .busOe(busOe), .waitAck(waitAck),
    .newFrame(newFrame), .memWrite(memWrite), .memRdEn(memRdEn), .memRdData(memRdData),
    .errFlags(errFlags), .memReady(memReady), .sclIn(sclIn), .sdaIn(sdaIn),
    .ctrlOut(ctrlOut)
  );

  function automatic logic [7:0] pixelAt(int k);
    return 8'((k * 37 + 11) & 255);
  endfunction

  // frame buffer read port model: data one cycle after the request
  always @(posedge clk) begin
    if (rstN && memRdEn) begin
      memRdData <= pixelAt(fetches);
      fetches   <= fetches + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writes(input int n);
    @(negedge clk); memWrite = 1'b1;
    repeat (n) @(negedge clk);
    memWrite = 1'b0;
  endtask

  task automatic frameStart();
    @(negedge clk); newFrame = 1'b1;
    @(negedge clk); newFrame = 1'b0;
  endtask

  task automatic hostCycle(input bit isData, input bit isWrite, input logic [7:0] wv,
                           output logic [7:0] rv, output bit gotAck, output bit oeSeen,
                           output bit released);
    gotAck = 1'b0;
    @(negedge clk); wrN = !isWrite; busIn = wv;
    @(negedge clk);
    if (isData) dsN = 1'b0; else asN = 1'b0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (waitAck) begin gotAck = 1'b1; break; end
    end
    rv = busOut; oeSeen = busOe;
    @(negedge clk); dsN = 1'b1; asN = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!waitAck) break;
    end
    released = !waitAck && !busOe;
    @(negedge clk); wrN = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rv;
    bit ack, oe, rel;
    int f0, oeBad;

    idle(3); rstN = 1'b1; @(negedge clk);
    check("R1 waitAck after reset", waitAck, 0);
    check("R1 busOe after reset", busOe, 0);
    check("R1 ctrlOut after reset", ctrlOut, 0);
    check("R1 memRdEn after reset", memRdEn, 0);

    // writes without any frame start: no fetch
    writes(700); idle(10);
    check("R8 no fetch before newFrame", fetches, 0);

    frameStart();
    writes(599); idle(10);
    check("R8 no fetch at threshold-1", fetches, 0);
    writes(1); idle(10);
    check("R8 fetch at threshold", fetches, 1);
    idle(40);
    check("R9 single fetch while unread", fetches, 1);

    for (int i = 0; i < 17; i++) begin
      hostCycle(1, 0, 8'h00, rv, ack, oe, rel);
      check("R2 data read ack", ack, 1);
      check("R2 R10 pixel value", rv, pixelAt(readIdx));
      check("R11 bus driven in data read", oe, 1);
      check("R3 released after strobe", rel, 1);
      readIdx++;
      idle(6);
      check("R9 one refetch per read", fetches, readIdx + 1);
    end

    // restart count while byte 17 is held
    frameStart(); idle(10);
    check("R8 newFrame blocks fetch", fetches, 18);
    hostCycle(1, 0, 8'h00, rv, ack, oe, rel);
    check("R2 held byte after restart", rv, pixelAt(readIdx));
    readIdx++;
    idle(20);
    check("R8 no fetch after restart", fetches, 18);

    // read with empty prefetch: stall
    @(negedge clk); wrN = 1'b1;
    @(negedge clk); dsN = 1'b0;
    idle(50);
    check("R4 waitAck low while empty", waitAck, 0);
    check("R11 bus released while stalled", busOe, 0);
    writes(599); idle(5);
    check("R4 still stalled at threshold-1", waitAck, 0);
    writes(1);
    ack = 1'b0;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (waitAck) begin ack = 1'b1; break; end
    end
    check("R4 ack after byte arrives", ack, 1);
    check("R4 R10 stalled pixel", busOut, pixelAt(readIdx));
    @(negedge clk); dsN = 1'b1;
    for (int i = 0; i < 100; i++) begin
      @(negedge clk);
      if (!waitAck) break;
    end
    check("R3 release after stalled read", int'(waitAck | busOe), 0);
    readIdx++;
    idle(10);

    // address write sweep over every value
    oeBad = 0;
    for (int v = 0; v < 256; v++) begin
      hostCycle(0, 1, 8'(v), rv, ack, oe, rel);
      if (oe) oeBad++;
      check("R5 ctrlOut loaded", ctrlOut, v);
    end
    check("R11 no drive during writes", oeBad, 0);
    hostCycle(0, 1, 8'h15, rv, ack, oe, rel);
    check("R5 camera select bit4", ctrlOut[4], 1);
    check("R5 memory reset bit2", ctrlOut[2], 1);
    check("R5 camera reset bit3", ctrlOut[3], 0);

    // address read sweep over every status combination
    for (int s = 0; s < 32; s++) begin
      @(negedge clk);
      errFlags = 2'(s); memReady = s[2]; sclIn = s[3]; sdaIn = s[4];
      idle(4);
      hostCycle(0, 0, 8'hFF, rv, ack, oe, rel);
      check("R6 status byte", rv, s);
      check("R11 bus driven in status read", oe, 1);
    end
    check("R12 ctrl unchanged by reads", ctrlOut, 8'h15);

    // data write discarded
    f0 = fetches;
    hostCycle(1, 1, 8'hC3, rv, ack, oe, rel);
    check("R7 data write acked", ack, 1);
    check("R7 ctrl unchanged", ctrlOut, 8'h15);
    check("R7 no fetch caused", fetches, f0);
    hostCycle(1, 0, 8'h00, rv, ack, oe, rel);
    check("R7 held pixel intact", rv, pixelAt(readIdx));
    readIdx++;
    idle(10);

    // reset in mid-stream
    @(negedge clk); rstN = 1'b0;
    idle(3);
    check("R1 waitAck in reset", waitAck, 0);
    rstN = 1'b1;
    f0 = fetches;
    writes(700); idle(10);
    check("R1 ctrl cleared", ctrlOut, 0);
    check("R1 disarmed after reset", fetches, f0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end
endmodule